// File: doc/BRIEF.md
# Exception Entry State Update

This block performs the architectural bookkeeping a 32-bit RISC core needs at the moment it takes an exception. The core presents a single-cycle request. The request carries a type code, a 32-bit flags word and an auxiliary fault address. Alongside it the core supplies its current instruction address, the address of the following instruction and the machine state word.

On the same clock edge, the block stores a return address and a saved status word in two save registers. For data storage faults it also captures the fault address and a fault status word. After that edge it pulses three outputs: a request to clear the machine state word, a redirect of fetch to the vector address (which is the type code itself), and a translation-cache invalidate.

The type decides which address is saved and how the status word is built. Most types save the current address and a masked copy of the machine state. System calls save the next address. Program exceptions choose between the two addresses using a flag bit. Some types merge the flags word into the saved status. A machine check forces the recoverable bit on. A request whose type code is not recognised is answered with an error pulse and leaves all state untouched.

Top module: `exc_entry`

## Requirements
- R1: While reset is low, and after it is released, every saved register and the vector output read zero, and all pulse outputs are low.
- R2: For external interrupt (0x500), FPU unavailable (0x800), decrementer (0x900), trace (0xD00) and floating assist (0xE00), the first save register gets the current address and the second gets the machine state ANDed with 0x87C0FFFF.
- R3: For a system call (0xC00), the first save register gets the next address. The second gets the machine state ANDed with 0x87C0FFFF.
- R4: For a program exception (0x700), the first save register gets the next address when flags bit 16 is set, and the current address otherwise. The second gets (machine state AND 0x87C0FFFF) OR flags.
- R5: For an instruction storage fault (0x400), the first save register gets the current address. The second gets (machine state AND 0x87C0FFFF) OR flags.
- R6: For a data storage fault (0x300), the fault address register gets the auxiliary address and the fault status register gets the flags word. The save registers are filled as in R2. No other type changes the fault address or fault status registers.
- R7: For vector unit unavailable (0xF20), the second save register gets the machine state ANDed with 0x0000FF73. The first gets the current address.
- R8: For a machine check (0x200), the second save register gets (machine state AND 0x87C0FFFF) with bit 1 set. The first gets the current address. If machine state bit 12 was clear at the request, mchk_off pulses for one cycle together with accepted.
- R9: In the cycle after a recognised request, accepted, msr_clear and tlb_inval are high for exactly one cycle. From then on, vector_pc holds the type code zero-extended to 32 bits. All saved values appear in that same cycle.
- R10: In the cycle after a request with an unrecognised type code, error is high for one cycle. accepted, msr_clear, tlb_inval and mchk_off stay low, and every saved register and vector_pc keeps its value.
- R11: Without a request, all pulse outputs are low in the following cycle and every saved register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Single-cycle exception request |
| req_type | input | 12 | Exception type code (vector offset) |
| req_flags | input | 32 | Per-type flags word |
| req_addr | input | 32 | Auxiliary fault address |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the following instruction |
| msr | input | 32 | Machine state word at the request |
| save_pc | output | 32 | First save register: return address |
| save_msr | output | 32 | Second save register: saved status |
| fault_addr | output | 32 | Data fault address register |
| fault_stat | output | 32 | Data fault status register |
| vector_pc | output | 32 | Fetch redirect target of the last accepted request |
| accepted | output | 1 | Pulse: request accepted, fetch redirected |
| msr_clear | output | 1 | Pulse: machine state word must be cleared |
| tlb_inval | output | 1 | Pulse: invalidate translation cache |
| error | output | 1 | Pulse: unknown type rejected |
| mchk_off | output | 1 | Pulse: machine check taken with enable bit clear |

## Verification
The bench builds the block with its default parameters. These are a 12-bit type field, the save masks 0x87C0FFFF and 0x0000FF73, the recoverable bit at position 1, the machine-check enable at bit 12 and the program "next" flag at bit 16. With those defaults, randomly drawn machine state and flags words reach every bit the masks let through and every bit they drop. Flag words with bit 16 both set and clear reach both return-address choices of the program exception. Machine state with bit 12 both set and clear reaches both outcomes of the enable check. The unknown codes placed among the valid ones (0x100, 0x600, 0xF00) sit next to real vectors, so a decode that is too broad or off by one shows up as a wrong accept or a changed register.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int              TYPE_W        = 12,
  parameter logic [31:0]     SAVE_MASK     = 32'h87C0_FFFF,
  parameter logic [31:0]     VEC_SAVE_MASK = 32'h0000_FF73,
  parameter logic [31:0]     RI_MASK       = 32'h0000_0002,
  parameter logic [31:0]     ME_MASK       = 32'h0000_1000,
  parameter logic [31:0]     NEXT_MASK     = 32'h0001_0000,
  parameter logic [TYPE_W-1:0] T_MCHK  = 12'h200,
  parameter logic [TYPE_W-1:0] T_DSTOR = 12'h300,
  parameter logic [TYPE_W-1:0] T_ISTOR = 12'h400,
  parameter logic [TYPE_W-1:0] T_EXT   = 12'h500,
  parameter logic [TYPE_W-1:0] T_PROG  = 12'h700,
  parameter logic [TYPE_W-1:0] T_NOFPU = 12'h800,
  parameter logic [TYPE_W-1:0] T_DEC   = 12'h900,
  parameter logic [TYPE_W-1:0] T_SCALL = 12'hC00,
  parameter logic [TYPE_W-1:0] T_TRACE = 12'hD00,
  parameter logic [TYPE_W-1:0] T_FPAST = 12'hE00,
  parameter logic [TYPE_W-1:0] T_NOVEC = 12'hF20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TYPE_W-1:0] req_type,
  input  logic [31:0]       req_flags,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       cur_pc,
  input  logic [31:0]       next_pc,
  input  logic [31:0]       msr,
  output logic [31:0]       save_pc,
  output logic [31:0]       save_msr,
  output logic [31:0]       fault_addr,
  output logic [31:0]       fault_stat,
  output logic [31:0]       vector_pc,
  output logic              accepted,
  output logic              msr_clear,
  output logic              tlb_inval,
  output logic              error,
  output logic              mchk_off
);

  localparam int PAD_W = 32 - TYPE_W;

  logic        known, use_next, merge_flags, force_ri, is_dfault;
  logic [31:0] keep_mask;

  always_comb begin
    known       = 1'b1;
    use_next    = 1'b0;
    merge_flags = 1'b0;
    force_ri    = 1'b0;
    is_dfault   = 1'b0;
    keep_mask   = SAVE_MASK;
    case (req_type)
      T_MCHK:  force_ri = 1'b1;
      T_DSTOR: is_dfault = 1'b1;
      T_ISTOR: merge_flags = 1'b1;
      T_PROG: begin
        merge_flags = 1'b1;
        use_next    = |(req_flags & NEXT_MASK);
      end
      T_SCALL: use_next = 1'b1;
      T_NOVEC: keep_mask = VEC_SAVE_MASK;
      T_EXT, T_NOFPU, T_DEC, T_TRACE, T_FPAST: ;
      default: known = 1'b0;
    endcase
  end

  wire take = req_valid && known;
  wire [31:0] status_nxt = (msr & keep_mask)
                         | (merge_flags ? req_flags : 32'h0)
                         | (force_ri ? RI_MASK : 32'h0);
  wire [31:0] ret_nxt = use_next ? next_pc : cur_pc;
  wire        me_clear = (msr & ME_MASK) == 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      save_pc    <= '0;
      save_msr   <= '0;
      fault_addr <= '0;
      fault_stat <= '0;
      vector_pc  <= '0;
      accepted   <= 1'b0;
      msr_clear  <= 1'b0;
      tlb_inval  <= 1'b0;
      error      <= 1'b0;
      mchk_off   <= 1'b0;
    end else begin
      accepted  <= take;
      msr_clear <= take;
      tlb_inval <= take;
      error     <= req_valid && !known;
      mchk_off  <= take && force_ri && me_clear;
      if (take) begin
        save_pc   <= ret_nxt;
        save_msr  <= status_nxt;
        vector_pc <= {{PAD_W{1'b0}}, req_type};
      end
      if (take && is_dfault) begin
        fault_addr <= req_addr;
        fault_stat <= req_flags;
      end
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int TYPE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [TYPE_W-1:0] req_type,
  input logic [31:0]       save_pc,
  input logic [31:0]       save_msr,
  input logic [31:0]       fault_addr,
  input logic [31:0]       fault_stat,
  input logic [31:0]       vector_pc,
  input logic              accepted,
  input logic              msr_clear,
  input logic              tlb_inval,
  input logic              error,
  input logic              mchk_off
);

  a_r9_pulses_together: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |-> (msr_clear && tlb_inval));

  a_r9_vector_is_type: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rst_n == 1'b0) |=> (accepted ? vector_pc == 32'(($past(req_type))) : 1'b1));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(accepted && error));

  a_r10_state_kept: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> ($stable(save_pc) && $stable(save_msr) && $stable(fault_addr)
               && $stable(fault_stat) && $stable(vector_pc)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!accepted && !error && !tlb_inval && !msr_clear && !mchk_off));

  a_r8_mchk_ri: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_off |-> (accepted && save_msr[1]));

endmodule

bind exc_entry exc_entry_chk #(.TYPE_W(TYPE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
  .save_pc(save_pc), .save_msr(save_msr), .fault_addr(fault_addr),
  .fault_stat(fault_stat), .vector_pc(vector_pc), .accepted(accepted),
  .msr_clear(msr_clear), .tlb_inval(tlb_inval), .error(error),
  .mchk_off(mchk_off));

// File: tb/exc_entry_tb.sv
module exc_entry_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_type = '0;
  logic [31:0] req_flags = '0, req_addr = '0, cur_pc = '0, next_pc = '0, msr = '0;
  logic [31:0] save_pc, save_msr, fault_addr, fault_stat, vector_pc;
  logic        accepted, msr_clear, tlb_inval, error, mchk_off;

  exc_entry u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_flags(req_flags), .req_addr(req_addr), .cur_pc(cur_pc),
    .next_pc(next_pc), .msr(msr), .save_pc(save_pc), .save_msr(save_msr),
    .fault_addr(fault_addr), .fault_stat(fault_stat), .vector_pc(vector_pc),
    .accepted(accepted), .msr_clear(msr_clear), .tlb_inval(tlb_inval),
    .error(error), .mchk_off(mchk_off));

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_pc = 0, m_st = 0, m_fa = 0, m_fs = 0, m_vec = 0;
  bit m_acc = 0, m_err = 0, m_mcf = 0;
  string tag = "R1";
  string drive_tag = "R11";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_st = 0; m_fa = 0; m_fs = 0; m_vec = 0;
      m_acc = 0; m_err = 0; m_mcf = 0; tag = "R1";
    end else begin
      m_acc = 0; m_err = 0; m_mcf = 0;
      tag = req_valid ? drive_tag : "R11";
      if (req_valid) begin
        int code;
        code = int'(req_type);
        m_acc = 1;
        case (code)
          'h200: begin m_pc = cur_pc; m_st = (msr & 32'h87C0FFFF) | 32'h2; m_mcf = (msr[12] == 1'b0); end
          'h300: begin m_pc = cur_pc; m_st = msr & 32'h87C0FFFF; m_fa = req_addr; m_fs = req_flags; end
          'h400: begin m_pc = cur_pc; m_st = (msr & 32'h87C0FFFF) | req_flags; end
          'h700: begin m_pc = req_flags[16] ? next_pc : cur_pc; m_st = (msr & 32'h87C0FFFF) | req_flags; end
          'hC00: begin m_pc = next_pc; m_st = msr & 32'h87C0FFFF; end
          'hF20: begin m_pc = cur_pc; m_st = msr & 32'h0000FF73; end
          'h500, 'h800, 'h900, 'hD00, 'hE00: begin m_pc = cur_pc; m_st = msr & 32'h87C0FFFF; end
          default: begin m_acc = 0; m_err = 1; end
        endcase
        if (m_acc) m_vec = code;
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(tag, "save_pc", save_pc, m_pc);
      chk(tag, "save_msr", save_msr, m_st);
      chk("R6", "fault_addr", fault_addr, m_fa);
      chk("R6", "fault_stat", fault_stat, m_fs);
      chk("R9", "vector_pc", vector_pc, m_vec);
      chk(tag, "accepted", 32'(accepted), 32'(m_acc));
      chk(tag, "msr_clear", 32'(msr_clear), 32'(m_acc));
      chk(tag, "tlb_inval", 32'(tlb_inval), 32'(m_acc));
      chk("R10", "error", 32'(error), 32'(m_err));
      chk("R8", "mchk_off", 32'(mchk_off), 32'(m_mcf));
    end
  end

  function automatic string tag_of(int code);
    case (code)
      'h200: return "R8";
      'h300: return "R6";
      'h400: return "R5";
      'h700: return "R4";
      'hC00: return "R3";
      'hF20: return "R7";
      'h500, 'h800, 'h900, 'hD00, 'hE00: return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic req(int code, logic [31:0] fl, logic [31:0] st);
    @(negedge clk);
    #1;
    req_valid = 1'b1;
    req_type  = 12'(code);
    req_flags = fl;
    req_addr  = $urandom;
    cur_pc    = $urandom & 32'hFFFF_FFFC;
    next_pc   = cur_pc + 4;
    msr       = st;
    drive_tag = tag_of(code);
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
    req_valid = 1'b0;
    req_type  = 12'($urandom);
    req_flags = $urandom;
    req_addr  = $urandom;
    msr       = $urandom;
  endtask

  localparam int NCODES = 14;
  int codes [NCODES] = '{'h200, 'h300, 'h400, 'h500, 'h700, 'h800, 'h900,
                         'hC00, 'hD00, 'hE00, 'hF20, 'h100, 'h600, 'hF00};

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle();
    // R1 R11: quiet after reset
    idle();
    req('h300, 32'h4200_0000, 32'hFFFF_FFFF);
    req('h500, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    idle();
    req('h700, 32'h0001_0000, 32'h1234_5678);
    req('h700, 32'h0002_0000, 32'h8765_4321);
    req('h200, 32'h0, 32'h0000_1000);
    req('h200, 32'h0, 32'hFFFF_EFFF);
    req('hF20, 32'h0, 32'hFFFF_FFFF);
    req('hC00, 32'h0, 32'hFFFF_FFFF);
    req('h400, 32'h4000_0000, 32'h0000_0030);
    req('h100, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    req('h600, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    idle();
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) idle();
      else req(codes[$urandom_range(0, NCODES - 1)], $urandom, $urandom);
    end
    idle();
    idle();
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule